// File: doc/BRIEF.md
# Clock Alarm and Frequency-Test Interrupt

This block produces the interrupt request of a real-time clock. It compares the running time (seconds, minutes, hours, date) against four alarm bytes. Each alarm byte carries a compare value in its low bits and a don't-care bit in its top bit. When the selected fields match on a 1 Hz tick, the block sets a sticky pending flag. The flag pulls the interrupt line low when alarms are enabled for the current power state. There is one enable for normal operation and a separate one for battery-backup operation, so an alarm can wake the system.

The same pin doubles as a frequency-test output. When the test condition holds, the pin toggles on every 1024 Hz tick, which gives a 512 Hz square wave. Reading the interrupt-control register clears the pending flag. The pin is modelled only as a pull-low request, never as a driven high level.

Top module: `rtc_alarm_irq`

## Requirements
- R1: While reset is asserted and after it is released, `alarm_pending` is 0 and `irq_drive_low` is 0 (line released) until an alarm or a test toggle occurs.
- R2: The repeat mode is taken from the four don't-care bits {date, hour, min, sec} (bit 7 of each alarm byte, 1 = ignore). With all four set (4'b1111), every 1 Hz tick sets the flag whatever the time.
- R3: With 4'b1110 (only the seconds bit clear), a tick sets the flag when the seconds match.
- R4: With 4'b1100, a tick sets the flag when the seconds and minutes both match.
- R5: With 4'b1000, a tick sets the flag when the seconds, minutes and hours all match.
- R6: With 4'b0000, a tick sets the flag only when the seconds, minutes, hours and date all match.
- R7: Any other don't-care combination behaves like 4'b1111: every tick sets the flag.
- R8: The flag is set only in a cycle where `tick_1hz` is 1. A matching time without a tick leaves the flag at 0.
- R9: A pulse on `ctl_read` clears the flag one cycle later. If a setting tick falls in the same cycle, the flag stays set.
- R10: With the test mode inactive, `irq_drive_low` equals the pending flag ANDed with `irq_bkp_en` when `in_backup` is 1, and ANDed with `irq_en` when `in_backup` is 0.
- R11: The test mode is active when `ftest_on & ~irq_en & (wd_steer | wd_count==0)`. While it is active, the line starts released and inverts on every `tick_1024hz`. When it is inactive, no toggling occurs.
- R12: While the test mode is active, it alone drives the line and the alarm path is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tick_1024hz | input | 1 | One-cycle pulse at 1024 Hz |
| in_backup | input | 1 | 1 while running from battery (data retention) |
| now_sec | input | 7 | Current seconds (BCD) |
| now_min | input | 7 | Current minutes (BCD) |
| now_hour | input | 7 | Current hours (BCD) |
| now_date | input | 7 | Current date (BCD) |
| alm_sec | input | 8 | Seconds alarm byte, bit 7 = don't-care |
| alm_min | input | 8 | Minutes alarm byte, bit 7 = don't-care |
| alm_hour | input | 8 | Hours alarm byte, bit 7 = don't-care |
| alm_date | input | 8 | Date alarm byte, bit 7 = don't-care |
| irq_en | input | 1 | Alarm enable in normal power |
| irq_bkp_en | input | 1 | Alarm enable in backup power |
| ftest_on | input | 1 | Frequency-test request bit |
| wd_steer | input | 1 | Watchdog steering bit |
| wd_count | input | 8 | Watchdog register contents |
| ctl_read | input | 1 | Pulse: interrupt-control register is being read |
| alarm_pending | output | 1 | Sticky alarm flag |
| irq_drive_low | output | 1 | 1 = pull the interrupt line low |

## Verification
Two functions can fall in the same cycle: a 1 Hz tick with a matching time that sets the flag, and a register read that clears it. The bench drives `ctl_read` and `tick_1hz` high together with the mask 4'b1111. It then expects the flag to stay set, and expects a later read on its own to clear it. In the same way, an enabled pending alarm and an active frequency test are raised together. The bench then judges that the line follows only the test toggle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   localparam int NUM_FIELDS = 4;

   typedef enum logic [2:0] {
      RPT_EVERY_SEC  = 3'd0,
      RPT_SEC        = 3'd1,
      RPT_MIN_SEC    = 3'd2,
      RPT_HMS        = 3'd3,
      RPT_FULL       = 3'd4
   } rpt_mode_e;

   // Don't-care bits ordered {date, hour, min, sec}; 1 = field ignored.
   function automatic rpt_mode_e decode_mask(input logic [NUM_FIELDS-1:0] m);
      rpt_mode_e r;
      case (m)
         4'b1111: r = RPT_EVERY_SEC;
         4'b1110: r = RPT_SEC;
         4'b1100: r = RPT_MIN_SEC;
         4'b1000: r = RPT_HMS;
         4'b0000: r = RPT_FULL;
         default: r = RPT_EVERY_SEC;
      endcase
      return r;
   endfunction

   // Number of low-order fields (sec upward) that must match.
   function automatic logic [2:0] fields_required(input rpt_mode_e md);
      logic [2:0] n;
      case (md)
         RPT_SEC:     n = 3'd1;
         RPT_MIN_SEC: n = 3'd2;
         RPT_HMS:     n = 3'd3;
         RPT_FULL:    n = 3'd4;
         default:     n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int VAL_W = 7
) (
   input  logic [NUM_FIELDS-1:0][VAL_W-1:0] now_v,
   input  logic [NUM_FIELDS-1:0][VAL_W-1:0] alm_v,
   input  logic [NUM_FIELDS-1:0]            mask,
   output rpt_mode_e                        mode,
   output logic                             hit
);

   logic [NUM_FIELDS-1:0] field_eq;
   logic [NUM_FIELDS-1:0] field_need;
   logic [2:0]            depth;

   if (VAL_W < 6 || VAL_W > 15) begin : g_bad_width
      $error("rtc_alarm_cmp: VAL_W out of range");
   end

   assign mode  = decode_mask(mask);
   assign depth = fields_required(mode);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      assign field_eq[i]   = (now_v[i] == alm_v[i]);
      assign field_need[i] = (depth > 3'(i));
   end

   assign hit = &(field_eq | ~field_need);

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);

   logic flag_nxt;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (set_req)      flag_nxt = 1'b1;
         else if (clr_req) flag_nxt = 1'b0;
         else              flag_nxt = flag;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr_req)      flag_nxt = 1'b0;
         else if (set_req) flag_nxt = 1'b1;
         else              flag_nxt = flag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_nxt;
   end

endmodule

// File: rtl/rtc_ftest_gen.sv
module rtc_ftest_gen #(
   parameter int WD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ftest_on,
   input  logic            irq_en,
   input  logic            wd_steer,
   input  logic [WD_W-1:0] wd_count,
   input  logic            tick_1024hz,
   output logic            active,
   output logic            phase
);

   if (WD_W < 1) begin : g_bad_wd
      $error("rtc_ftest_gen: WD_W must be positive");
   end

   logic wd_zero;

   assign wd_zero = (wd_count == '0);
   assign active  = ftest_on & ~irq_en & (wd_steer | wd_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           phase <= 1'b0;
      else if (!active)     phase <= 1'b0;
      else if (tick_1024hz) phase <= ~phase;
   end

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int WD_W     = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1hz,
   input  logic             tick_1024hz,
   input  logic             in_backup,
   input  logic [REG_W-2:0] now_sec,
   input  logic [REG_W-2:0] now_min,
   input  logic [REG_W-2:0] now_hour,
   input  logic [REG_W-2:0] now_date,
   input  logic [REG_W-1:0] alm_sec,
   input  logic [REG_W-1:0] alm_min,
   input  logic [REG_W-1:0] alm_hour,
   input  logic [REG_W-1:0] alm_date,
   input  logic             irq_en,
   input  logic             irq_bkp_en,
   input  logic             ftest_on,
   input  logic             wd_steer,
   input  logic [WD_W-1:0]  wd_count,
   input  logic             ctl_read,
   output logic             alarm_pending,
   output logic             irq_drive_low
);

   localparam int VAL_W    = REG_W - 1;
   localparam int MASK_BIT = REG_W - 1;

   if (REG_W < 7 || REG_W > 16) begin : g_bad_reg
      $error("rtc_alarm_irq: REG_W out of range");
   end

   logic [NUM_FIELDS-1:0][VAL_W-1:0] now_v;
   logic [NUM_FIELDS-1:0][VAL_W-1:0] alm_v;
   logic [NUM_FIELDS-1:0]            field_mask;
   logic [NUM_FIELDS-1:0][REG_W-1:0] alm_raw;
   rpt_mode_e                        rpt_mode;
   logic                             hit;
   logic                             ft_active;
   logic                             ft_phase;
   logic                             alarm_low;

   // Field order: 0 = seconds, 1 = minutes, 2 = hours, 3 = date
   assign now_v[0] = now_sec;
   assign now_v[1] = now_min;
   assign now_v[2] = now_hour;
   assign now_v[3] = now_date;

   assign alm_raw[0] = alm_sec;
   assign alm_raw[1] = alm_min;
   assign alm_raw[2] = alm_hour;
   assign alm_raw[3] = alm_date;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_split
      assign alm_v[f]      = alm_raw[f][VAL_W-1:0];
      assign field_mask[f] = alm_raw[f][MASK_BIT];
   end

   rtc_alarm_cmp #(
      .VAL_W (VAL_W)
   ) i_cmp (
      .now_v (now_v),
      .alm_v (alm_v),
      .mask  (field_mask),
      .mode  (rpt_mode),
      .hit   (hit)
   );

   rtc_alarm_flag #(
      .SET_WINS (SET_WINS)
   ) i_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (tick_1hz & hit),
      .clr_req (ctl_read),
      .flag    (alarm_pending)
   );

   rtc_ftest_gen #(
      .WD_W (WD_W)
   ) i_ftest (
      .clk         (clk),
      .rst_n       (rst_n),
      .ftest_on    (ftest_on),
      .irq_en      (irq_en),
      .wd_steer    (wd_steer),
      .wd_count    (wd_count),
      .tick_1024hz (tick_1024hz),
      .active      (ft_active),
      .phase       (ft_phase)
   );

   assign alarm_low     = alarm_pending & (in_backup ? irq_bkp_en : irq_en);
   assign irq_drive_low = ft_active ? ft_phase : alarm_low;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1hz,
   input logic       tick_1024hz,
   input logic       in_backup,
   input logic       irq_en,
   input logic       irq_bkp_en,
   input logic       ctl_read,
   input logic [3:0] mask,
   input logic       hit,
   input logic       ft_active,
   input logic       alarm_pending,
   input logic       irq_drive_low
);

   logic past_ok;
   logic mask_known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign mask_known = (mask == 4'b1111) || (mask == 4'b1110) || (mask == 4'b1100) ||
                       (mask == 4'b1000) || (mask == 4'b0000);

   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !alarm_pending || !rst_n);

   assert_every_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && mask == 4'b1111) |=> alarm_pending);

   assert_unknown_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !mask_known) |=> alarm_pending);

   assert_set_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && hit) |=> alarm_pending);

   assert_no_tick_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_pending && !tick_1hz) |=> !alarm_pending);

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_read && !(tick_1hz && hit)) |=> !alarm_pending);

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ft_active && !(alarm_pending && (in_backup ? irq_bkp_en : irq_en))) |-> !irq_drive_low);

   assert_backup_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ft_active && alarm_pending && in_backup && irq_bkp_en) |-> irq_drive_low);

   assert_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ft_active && $past(ft_active) && $past(tick_1024hz))
         |-> (irq_drive_low != $past(irq_drive_low)));

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ft_active && $past(ft_active) && !$past(tick_1024hz)) |-> $stable(irq_drive_low));

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_1hz      (tick_1hz),
   .tick_1024hz   (tick_1024hz),
   .in_backup     (in_backup),
   .irq_en        (irq_en),
   .irq_bkp_en    (irq_bkp_en),
   .ctl_read      (ctl_read),
   .mask          (field_mask),
   .hit           (hit),
   .ft_active     (ft_active),
   .alarm_pending (alarm_pending),
   .irq_drive_low (irq_drive_low)
);

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       tick_1024hz = 1'b0;
   logic       in_backup = 1'b0;
   logic [6:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
   logic [7:0] alm_sec = 8'h80, alm_min = 8'h80, alm_hour = 8'h80, alm_date = 8'h80;
   logic       irq_en = 1'b0;
   logic       irq_bkp_en = 1'b0;
   logic       ftest_on = 1'b0;
   logic       wd_steer = 1'b0;
   logic [7:0] wd_count = 8'h10;
   logic       ctl_read = 1'b0;
   logic       alarm_pending;
   logic       irq_drive_low;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_alarm_irq i_rtc_alarm_irq (
      .clk (clk), .rst_n (rst_n), .tick_1hz (tick_1hz), .tick_1024hz (tick_1024hz),
      .in_backup (in_backup), .now_sec (now_sec), .now_min (now_min),
      .now_hour (now_hour), .now_date (now_date), .alm_sec (alm_sec),
      .alm_min (alm_min), .alm_hour (alm_hour), .alm_date (alm_date),
      .irq_en (irq_en), .irq_bkp_en (irq_bkp_en), .ftest_on (ftest_on),
      .wd_steer (wd_steer), .wd_count (wd_count), .ctl_read (ctl_read),
      .alarm_pending (alarm_pending), .irq_drive_low (irq_drive_low)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Clear flag with a lone read, then one 1 Hz tick; sample after it lands.
   task automatic tick_and_sample();
      @(negedge clk); ctl_read = 1'b1; tick_1hz = 1'b0;
      @(negedge clk); ctl_read = 1'b0; tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic pulse_1024();
      @(negedge clk); tick_1024hz = 1'b1;
      @(negedge clk); tick_1024hz = 1'b0;
   endtask

   function automatic string req_for(input logic [3:0] m);
      case (m)
         4'b1111: return "R2";
         4'b1110: return "R3";
         4'b1100: return "R4";
         4'b1000: return "R5";
         4'b0000: return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [6:0] base [4];
      base[0] = 7'h37; base[1] = 7'h42; base[2] = 7'h19; base[3] = 7'h28;

      // R1: idle during and after reset
      repeat (3) @(negedge clk);
      chk("R1 pending in reset", alarm_pending, 1'b0);
      chk("R1 line in reset", irq_drive_low, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 pending after reset", alarm_pending, 1'b0);
      chk("R1 line after reset", irq_drive_low, 1'b0);

      // R2..R7: sweep all masks against all field-equality patterns
      irq_en = 1'b1;
      now_sec = base[0]; now_min = base[1]; now_hour = base[2]; now_date = base[3];
      for (int m = 0; m < 16; m++) begin
         for (int e = 0; e < 16; e++) begin
            logic [3:0] mk, eq, need;
            logic       defined, expv;
            int         k;
            mk = 4'(m); eq = 4'(e);
            defined = 1'b0; k = 0;
            for (int j = 0; j <= 4; j++)
               if (((4'hF << j) & 4'hF) == mk) begin defined = 1'b1; k = j; end
            need = 4'((1 << k) - 1);
            expv = defined ? &(eq | ~need) : 1'b1;
            @(negedge clk);
            alm_sec  = {mk[0], eq[0] ? base[0] : base[0] ^ 7'h01};
            alm_min  = {mk[1], eq[1] ? base[1] : base[1] ^ 7'h02};
            alm_hour = {mk[2], eq[2] ? base[2] : base[2] ^ 7'h10};
            alm_date = {mk[3], eq[3] ? base[3] : base[3] ^ 7'h04};
            tick_and_sample();
            chk(req_for(mk), alarm_pending, expv);
            chk("R10 line follows flag", irq_drive_low, expv);
         end
      end

      // R8: full match but no tick never sets the flag
      @(negedge clk);
      alm_sec = {1'b0, base[0]}; alm_min = {1'b0, base[1]};
      alm_hour = {1'b0, base[2]}; alm_date = {1'b0, base[3]};
      ctl_read = 1'b1;
      @(negedge clk); ctl_read = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 no tick no set", alarm_pending, 1'b0);

      // R9: read and setting tick together -> set wins; lone read clears
      alm_sec = 8'h80; alm_min = 8'h80; alm_hour = 8'h80; alm_date = 8'h80;
      @(negedge clk); ctl_read = 1'b1; tick_1hz = 1'b1;
      @(negedge clk); ctl_read = 1'b0; tick_1hz = 1'b0;
      chk("R9 set wins over read", alarm_pending, 1'b1);
      @(negedge clk); ctl_read = 1'b1;
      @(negedge clk); ctl_read = 1'b0;
      chk("R9 read clears", alarm_pending, 1'b0);

      // R10: power mode x enables with a pending flag
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         in_backup = c[0]; irq_en = c[1]; irq_bkp_en = c[2];
         @(negedge clk);
         chk("R10 enable by power mode", irq_drive_low, c[0] ? c[2] : c[1]);
      end
      in_backup = 1'b0; irq_en = 1'b0; irq_bkp_en = 1'b0;

      // R11: gating expression sweep with the flag cleared
      @(negedge clk); ctl_read = 1'b1;
      @(negedge clk); ctl_read = 1'b0;
      for (int c = 0; c < 16; c++) begin
         logic act;
         @(negedge clk);
         ftest_on = c[0]; irq_en = c[1]; wd_steer = c[2];
         wd_count = c[3] ? 8'h00 : 8'h5A;
         act = c[0] & ~c[1] & (c[2] | c[3]);
         @(negedge clk);
         chk("R11 starts released", irq_drive_low, 1'b0);
         pulse_1024();
         chk("R11 first toggle", irq_drive_low, act);
         pulse_1024();
         chk("R11 second toggle", irq_drive_low, 1'b0);
         @(negedge clk); ftest_on = 1'b0;
         @(negedge clk);
      end
      irq_en = 1'b0; wd_steer = 1'b0; wd_count = 8'h10;

      // R12: test mode overrides a backup wake-up alarm
      @(negedge clk); in_backup = 1'b1; irq_bkp_en = 1'b1; tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      chk("R10 backup wake asserted", irq_drive_low, 1'b1);
      @(negedge clk); ftest_on = 1'b1; wd_steer = 1'b1;
      @(negedge clk);
      chk("R12 test overrides alarm", irq_drive_low, 1'b0);
      pulse_1024();
      chk("R12 test toggle drives", irq_drive_low, 1'b1);
      pulse_1024();
      chk("R12 test toggle releases", irq_drive_low, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule